// File: doc/BRIEF.md
# Dead-Time PWM Pulse Generator

A 10-bit pulse generator for driving one power switch. Each period has three phases. The output is first held inactive for a programmable dead time. It is then driven active for a programmable pulse width, and it returns to inactive until the counter reaches the programmed period value. The counter then wraps to zero and a one-clock period interrupt is raised.

The period, width and dead-time values are written one byte at a time over a simple synchronous register bus. Writes land in shadow copies, and all three become active together when the upper byte of the period value is written. A mode register selects:
- how a stop request is handled,
- continuous or single-period operation,
- whether the first period interrupt after a start is suppressed,
- the active output level.

A control register carries the start request and an emergency release. It also reports a counting flag, kept apart from the start bit, and an emergency flag. A synchronous, active-high emergency input forces the output off at once.

Top module: `dtpwm_top`

## Requirements
- R1: After reset every data byte, the mode register and the control register read 0, and out_o and irq_o are 0. Byte addresses: 0/1 period low/high, 2/3 width low/high, 4/5 dead time low/high, 6 mode, 7 control. A high byte reads back only its two value bits.
- R2: Writes to any data byte leave the running values unchanged until address 1 (period high) is written. That write makes all three new values active together.
- R3: While counting, with counter value c running 0..P, the output is at its active level when D <= c < D+W, and inactive otherwise. One period lasts P+1 clocks.
- R4: irq_o is high for exactly one clock each time the counter wraps from P to 0.
- R5: With mode bit 3 set, the interrupt at the end of the first period after a start command is suppressed, and later ones occur.
- R6: With mode bit 2 set (one-shot), one period is produced, with its end interrupt. Counting then stops, the output goes inactive and the start bit stays 1.
- R7: Stop mode 00 (mode bits 1:0) stops counting at once, clears the counter and returns the output to its inactive level. Encoding 11 behaves the same.
- R8: Stop mode 01 stops at once and holds the output at the level it had when the stop was written.
- R9: Stop mode 10 clears the start bit (control bit 0) at once, but the counting flag (control bit 6) stays 1 until the current period ends. Then counting stops with a final interrupt.
- R10: Writing the control register with bit 0 set while counting clears the counter and restarts the waveform from its first phase.
- R11: Writes to the mode register are ignored while the counting flag is 1.
- R12: emg_i forces out_o inactive in the same cycle, sets control bit 7 and stops counting. Starts are refused while bit 7 is set. Writing control bit 1 clears bit 7 only when the start bit is 0, and bit 1 always reads 0.
- R13: Mode bit 4 set makes the active level 0 and the inactive level 1, including while stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| emg_i | input | 1 | Emergency stop, active high, synchronous |
| out_o | output | 1 | Pulse output |
| irq_o | output | 1 | Period interrupt, one-clock pulse |

## Verification
The deferred stop is the hardest case to reach from the ports. The stop request must land mid-period, and the bench must then see the start bit clear while the counting flag stays set until the exact wrap clock. The stimulus starts a known period, counts clocks from the start write, issues the stop at a chosen counter value, and reads the control register at the last counting clock and at the first idle clock. The same clock-counted placement puts the hold-level stop and the emergency input inside the active phase, where a wrong output level is visible.

// File: rtl/dtpwm_pkg.sv
package dtpwm_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [2:0] {
    A_PER_LO = 3'd0, A_PER_HI = 3'd1,
    A_WID_LO = 3'd2, A_WID_HI = 3'd3,
    A_DT_LO  = 3'd4, A_DT_HI  = 3'd5,
    A_MODE   = 3'd6, A_CTRL   = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    STOP_INIT = 2'b00,
    STOP_HOLD = 2'b01,
    STOP_EOP  = 2'b10,
    STOP_RSVD = 2'b11
  } stop_mode_e;

  typedef struct packed {
    logic       act_low;
    logic       sup_first;
    logic       one_shot;
    stop_mode_e stop_mode;
  } mode_t;

  localparam int MODE_W    = $bits(mode_t);
  localparam int CTL_START = 0;
  localparam int CTL_REL   = 1;
endpackage

// File: rtl/dtpwm_regs.sv
module dtpwm_regs
  import dtpwm_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int NREG  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [CNT_W-1:0]  per_o,
  output logic [CNT_W-1:0]  wid_o,
  output logic [CNT_W-1:0]  dt_o,
  output logic [7:0]        rd_byte_o,
  output logic              commit_o
);
  localparam int HI_W = CNT_W - 8;

  logic [NREG-1:0][CNT_W-1:0] sh_q;
  logic [NREG-1:0][CNT_W-1:0] act_q;

  assign commit_o = we_i && (addr_i == A_PER_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      act_q <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (we_i && addr_i[2:1] == 2'(i)) begin
          if (addr_i[0]) sh_q[i][CNT_W-1:8] <= wdata_i[HI_W-1:0];
          else           sh_q[i][7:0]       <= wdata_i;
        end
      end
      // period high byte arrives with the commit itself
      if (commit_o) begin
        act_q                <= sh_q;
        act_q[0][CNT_W-1:8]  <= wdata_i[HI_W-1:0];
      end
    end
  end

  always_comb begin
    rd_byte_o = '0;
    for (int i = 0; i < NREG; i++) begin
      if (addr_i[2:1] == 2'(i)) begin
        if (addr_i[0]) rd_byte_o = 8'(sh_q[i][CNT_W-1:8]);
        else           rd_byte_o = sh_q[i][7:0];
      end
    end
  end

  assign per_o = act_q[0];
  assign wid_o = act_q[1];
  assign dt_o  = act_q[2];

  // R2
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_o |=> $stable({per_o, wid_o, dt_o}));
endmodule

// File: rtl/dtpwm_ctrl.sv
module dtpwm_ctrl
  import dtpwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              emg_i,
  input  logic              wrap_i,
  input  logic              win_i,
  output logic              run_o,
  output logic              clr_o,
  output logic              sup_o,
  output logic              idle_act_o,
  output mode_t             mode_o,
  output logic              start_o,
  output logic              emg_flag_o
);
  mode_t mode_q;
  logic  run_q, start_q, emg_q, pend_q, first_q, idle_act_q;
  logic  ctrl_wr, mode_wr, go, halt, halt_now;
  logic  unused_w;

  assign unused_w = ^wdata_i[7:MODE_W];

  assign ctrl_wr  = we_i && (addr_i == A_CTRL);
  assign mode_wr  = we_i && (addr_i == A_MODE) && !run_q;
  assign go       = ctrl_wr && wdata_i[CTL_START] && !emg_q && !emg_i;
  assign halt     = ctrl_wr && !wdata_i[CTL_START] && run_q && !emg_i;
  assign halt_now = halt && (mode_q.stop_mode != STOP_EOP);

  assign clr_o = emg_i || go || halt_now;
  assign sup_o = first_q && mode_q.sup_first;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= '0;
      run_q      <= 1'b0;
      start_q    <= 1'b0;
      emg_q      <= 1'b0;
      pend_q     <= 1'b0;
      first_q    <= 1'b0;
      idle_act_q <= 1'b0;
    end else begin
      if (mode_wr) mode_q <= mode_t'(wdata_i[MODE_W-1:0]);
      if (ctrl_wr) start_q <= wdata_i[CTL_START];
      if (emg_i) begin
        emg_q      <= 1'b1;
        run_q      <= 1'b0;
        pend_q     <= 1'b0;
        idle_act_q <= 1'b0;
      end else begin
        if (ctrl_wr && wdata_i[CTL_REL] && !start_q) emg_q <= 1'b0;
        if (go) begin
          run_q   <= 1'b1;
          pend_q  <= 1'b0;
          first_q <= 1'b1;
        end else if (halt) begin
          if (mode_q.stop_mode == STOP_EOP) begin
            if (wrap_i) begin
              run_q      <= 1'b0;
              idle_act_q <= 1'b0;
            end else begin
              pend_q <= 1'b1;
            end
          end else begin
            run_q      <= 1'b0;
            idle_act_q <= (mode_q.stop_mode == STOP_HOLD) ? win_i : 1'b0;
          end
        end else if (wrap_i) begin
          first_q <= 1'b0;
          if (pend_q || mode_q.one_shot) begin
            run_q      <= 1'b0;
            pend_q     <= 1'b0;
            idle_act_q <= 1'b0;
          end
        end
      end
    end
  end

  assign run_o      = run_q;
  assign idle_act_o = idle_act_q;
  assign mode_o     = mode_q;
  assign start_o    = start_q;
  assign emg_flag_o = emg_q;

  // R12
  emg_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emg_i |=> (!run_q && emg_q));
  // R12
  run_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> !emg_q);
  // R11
  mode_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> $stable(mode_q));
  // R6
  one_shot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && wrap_i && mode_q.one_shot && !go && !emg_i) |=> !run_q);
endmodule

// File: rtl/dtpwm_core.sv
module dtpwm_core #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             sup_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] wid_i,
  input  logic [CNT_W-1:0] dt_i,
  input  logic             emg_i,
  input  logic             act_low_i,
  input  logic             idle_act_i,
  output logic             out_o,
  output logic             irq_o,
  output logic             wrap_o,
  output logic             win_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   win_end;
  logic             irq_q, lvl_act;

  assign win_end = {1'b0, dt_i} + {1'b0, wid_i};
  assign win_o   = (cnt_q >= dt_i) && ({1'b0, cnt_q} < win_end);
  // >= so a period shrunk below the count still wraps
  assign wrap_o  = run_i && (cnt_q >= per_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= wrap_o && !sup_i && !clr_i;
      if (clr_i)       cnt_q <= '0;
      else if (run_i)  cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
    end
  end

  assign lvl_act = run_i ? win_o : idle_act_i;
  assign out_o   = emg_i ? act_low_i : (lvl_act ^ act_low_i);
  assign irq_o   = irq_q;

  // R4
  irq_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (cnt_q == '0));
  // R10
  clr_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && !irq_o));
endmodule

// File: rtl/dtpwm_top.sv
module dtpwm_top
  import dtpwm_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              emg_i,
  output logic              out_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] per, wid, dt;
  logic [7:0]       reg_byte;
  logic             commit, run, clr, sup, idle_act, start, emg_flag, wrap, win;
  mode_t            mode;

  dtpwm_regs #(.CNT_W(CNT_W), .NREG(3)) i_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .per_o(per), .wid_o(wid), .dt_o(dt),
    .rd_byte_o(reg_byte), .commit_o(commit)
  );

  dtpwm_ctrl i_ctrl (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .emg_i,
    .wrap_i(wrap), .win_i(win),
    .run_o(run), .clr_o(clr), .sup_o(sup), .idle_act_o(idle_act),
    .mode_o(mode), .start_o(start), .emg_flag_o(emg_flag)
  );

  dtpwm_core #(.CNT_W(CNT_W)) i_core (
    .clk_i, .rst_ni, .run_i(run), .clr_i(clr), .sup_i(sup),
    .per_i(per), .wid_i(wid), .dt_i(dt), .emg_i,
    .act_low_i(mode.act_low), .idle_act_i(idle_act),
    .out_o, .irq_o, .wrap_o(wrap), .win_o(win)
  );

  always_comb begin
    case (addr_i)
      A_MODE:  rdata_o = 8'(mode);
      A_CTRL:  rdata_o = {emg_flag, run, 5'b0, start};
      default: rdata_o = reg_byte;
    endcase
  end

  logic unused_c;
  assign unused_c = commit;

  // R12
  emg_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emg_i |-> (out_o == mode.act_low));
  // R9
  eop_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !start && !emg_i && !wrap && !(we_i && addr_i == A_CTRL)) |=> run);
endmodule

// File: tb/test_dtpwm_top.sv
module test_dtpwm_top;
  logic       clk, rst_n, we, emg;
  logic [2:0] addr;
  logic [7:0] wdata, rdata;
  logic       out, irq;
  int n_tests = 0;
  int n_fail  = 0;

  dtpwm_top i_dtpwm_top (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .emg_i(emg), .out_o(out), .irq_o(irq)
  );

  initial begin
    clk = 0;
    forever #4 clk = ~clk;
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic set_params(input int p, input int d, input int w);
    wr(2, 8'(w)); wr(3, 8'(w >> 8));
    wr(4, 8'(d)); wr(5, 8'(d >> 8));
    wr(0, 8'(p)); wr(1, 8'(p >> 8));
  endtask

  // cycle k=0 is the first clock after the start (or restart) write
  task automatic wave(input string req, input int p, input int d, input int w,
                      input bit sup, input bit one, input bit al, input int n);
    int bad = 0;
    int ba = 0;
    int be = 0;
    for (int k = 0; k < n; k++) begin
      int m;
      bit done, win, eo, ei;
      m    = k % (p + 1);
      done = one && (k > p);
      win  = !done && (m >= d) && (m < d + w);
      eo   = win ^ al;
      ei   = (k > 0) && (m == 0) && !(sup && k == p + 1) && !(one && k > p + 1);
      if ((out !== eo || irq !== ei) && bad == 0) begin
        bad = 1;
        ba  = {out, irq};
        be  = {eo, ei};
        $display("  wave mismatch at cycle %0d ({out,irq})", k);
      end
      @(negedge clk);
    end
    chk(bad == 0, req, ba, be);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk(out == 0 && irq == 0, "R1 outputs", {out, irq}, 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk(v == 0, "R1 reset read", v, 0);
    end
    @(negedge clk);
  endtask

  task automatic t_readback();
    logic [7:0] v;
    wr(0, 8'hA5); wr(1, 8'hFF);
    rd(1, v); chk(v == 8'h03, "R1 high byte", v, 3);
    rd(0, v); chk(v == 8'hA5, "R1 low byte", v, 8'hA5);
    wr(4, 8'h3C); rd(4, v); chk(v == 8'h3C, "R1 dead low", v, 8'h3C);
    @(negedge clk);
  endtask

  task automatic t_wave();
    set_params(9, 2, 4);
    wr(7, 1);
    wave("R3 basic", 9, 2, 4, 0, 0, 0, 35);
    wr(7, 0);
    set_params(5, 1, 10);
    wr(7, 1);
    wave("R3 wide pulse", 5, 1, 10, 0, 0, 0, 20);
    wr(7, 0);
    set_params(3, 0, 2);
    wr(7, 1);
    wave("R4 short period", 3, 0, 2, 0, 0, 0, 16);
    wr(7, 0);
    set_params(9, 2, 4);
  endtask

  task automatic t_suppress();
    wr(6, 8'h08);
    wr(7, 1);
    wave("R5 first irq", 9, 2, 4, 1, 0, 0, 32);
    wr(7, 0);
    wr(6, 0);
  endtask

  task automatic t_shadow();
    wr(2, 1); wr(3, 0); wr(4, 0); wr(5, 0);
    wr(7, 1);
    wave("R2 before commit", 9, 2, 4, 0, 0, 0, 20);
    wr(7, 0);
    wr(1, 0);
    wr(7, 1);
    wave("R2 after commit", 9, 0, 1, 0, 0, 0, 20);
    wr(7, 0);
    set_params(9, 2, 4);
  endtask

  task automatic t_oneshot();
    logic [7:0] v;
    wr(6, 8'h04);
    wr(7, 1);
    wave("R6 one period", 9, 2, 4, 0, 1, 0, 15);
    rd(7, v); chk(v == 8'h01, "R6 status", v, 1);
    @(negedge clk);
    wr(7, 0);
    wr(6, 0);
  endtask

  task automatic t_stop_now(input logic [7:0] md, input string req);
    logic [7:0] v;
    wr(6, md);
    wr(7, 1);
    repeat (3) @(negedge clk);
    wr(7, 0);
    rd(7, v);
    chk(v == 0 && out == 0, req, {v, 7'b0, out}, 0);
    @(negedge clk);
    repeat (4) @(negedge clk);
    chk(out == 0 && irq == 0, req, {out, irq}, 0);
    wr(6, 0);
  endtask

  task automatic t_stop_hold();
    logic [7:0] v;
    wr(6, 8'h01);
    wr(7, 1);
    repeat (3) @(negedge clk);
    wr(7, 0);
    rd(7, v);
    chk(v == 0 && out == 1, "R8 hold level", {v, 7'b0, out}, 1);
    @(negedge clk);
    repeat (6) @(negedge clk);
    chk(out == 1, "R8 still held", out, 1);
    wr(6, 0);
  endtask

  task automatic t_stop_eop();
    logic [7:0] v;
    wr(6, 8'h02);
    wr(7, 1);
    repeat (3) @(negedge clk);
    wr(7, 0);
    rd(7, v); chk(v == 8'h40, "R9 after stop write", v, 8'h40);
    @(negedge clk);
    repeat (4) @(negedge clk);
    rd(7, v); chk(v == 8'h40, "R9 last counting clock", v, 8'h40);
    @(negedge clk);
    rd(7, v);
    chk(v == 0 && irq == 1 && out == 0, "R9 stopped at wrap", {v, 6'b0, irq, out}, 2);
    @(negedge clk);
    wr(6, 0);
  endtask

  task automatic t_restart();
    wr(7, 1);
    repeat (6) @(negedge clk);
    wr(7, 1);
    wave("R10 restart", 9, 2, 4, 0, 0, 0, 25);
    wr(7, 0);
  endtask

  task automatic t_mode_lock();
    logic [7:0] v;
    wr(7, 1);
    wr(6, 8'h1F);
    rd(6, v); chk(v == 0, "R11 locked", v, 0);
    @(negedge clk);
    wr(7, 0);
    wr(6, 8'h04);
    rd(6, v); chk(v == 8'h04, "R11 idle write", v, 4);
    @(negedge clk);
    wr(6, 0);
  endtask

  task automatic t_polarity();
    wr(6, 8'h10);
    #1;
    chk(out == 1, "R13 idle level", out, 1);
    @(negedge clk);
    wr(7, 1);
    wave("R13 inverted wave", 9, 2, 4, 0, 0, 1, 22);
    wr(7, 0);
    #1;
    chk(out == 1, "R13 after stop", out, 1);
    @(negedge clk);
    wr(6, 0);
  endtask

  task automatic t_emergency();
    logic [7:0] v;
    wr(7, 1);
    repeat (3) @(negedge clk);
    emg = 1;
    #1;
    chk(out == 0, "R12 same-cycle off", out, 0);
    @(negedge clk);
    emg = 0;
    rd(7, v); chk(v == 8'h81 && out == 0, "R12 flag set", v, 8'h81);
    @(negedge clk);
    wr(7, 1);
    rd(7, v); chk(v == 8'h81, "R12 start refused", v, 8'h81);
    @(negedge clk);
    wr(7, 3);
    rd(7, v); chk(v == 8'h81, "R12 release with start set", v, 8'h81);
    @(negedge clk);
    wr(7, 0);
    wr(7, 2);
    rd(7, v); chk(v == 0, "R12 released", v, 0);
    @(negedge clk);
    wr(7, 1);
    rd(7, v); chk(v == 8'h41, "R12 restart ok", v, 8'h41);
    @(negedge clk);
    wr(7, 0);
  endtask

  initial begin
    rst_n = 0; we = 0; emg = 0; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_wave();
    t_suppress();
    t_shadow();
    t_oneshot();
    t_stop_now(8'h00, "R7 mode 00");
    t_stop_now(8'h03, "R7 mode 11");
    t_stop_hold();
    t_stop_eop();
    t_restart();
    t_mode_lock();
    t_polarity();
    t_emergency();
    summary();
    $finish;
  end
endmodule